// File: doc/BRIEF.md
# On-Screen-Display Background Window Mixer

This block lays up to three rectangular background windows over a character-based on-screen-display raster. Each window is set by an inclusive row range, an inclusive column range, an enable bit and a 3-bit colour. The raster logic upstream presents the current character row and column, a flag that is high while a character dot is being drawn, and that dot's colour. From these the block produces the final colour, a half-tone signal for dimming the video amplifiers behind a window, a fast-blank signal for the video switch, and an output-enable flag.

When windows overlap, the lowest-numbered window supplies the colour. A window whose start lies beyond its end is not drawn. Positions outside the character grid are never inside a window. A single configuration bit decides whether fast blank also covers window areas or only character dots. A global display enable forces every output low. All outputs are registered, so each result appears one clock after the inputs that cause it.

Top module: `osd_window_mixer`

## Requirements
- R1: Window 0 has the highest priority and window 2 the lowest. Where enabled windows overlap, the colour of the lowest-numbered window covering the position is used.
- R2: A window takes effect only while its bit in `w_en` (bit i for window i) is 1.
- R3: A window with start row greater than end row, or with start column greater than end column, covers no position.
- R4: Window bounds are inclusive. A position is inside window i when lo <= position <= hi holds for both the row and the column.
- R5: Positions with row 10 or more, or with column 24 or more, lie inside no window.
- R6: `htone` is high when the position is inside an effective window and `char_dot` is 0. It is low otherwise.
- R7: `rgb_out` (R at bit 2, G at bit 1, B at bit 0) is the bitwise OR of two terms. The first is `char_rgb` when `char_dot` is 1, and zero otherwise. The second is the selected window colour when `htone` would be high, and zero otherwise.
- R8: With `fb_char_only` = 0, `fblank` is high on a character dot or inside an effective window. With `fb_char_only` = 1, it is high only on a character dot.
- R9: With `disp_en` = 0, `rgb_out`, `htone`, `fblank` and `out_en` are all 0. With `disp_en` = 1, `out_en` is 1.
- R10: Every output is registered. It reflects the inputs sampled at the previous rising clock edge, and it is 0 while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_en | input | 1 | Global display enable |
| fb_char_only | input | 1 | Fast-blank mode: 1 limits fast blank to character dots |
| cur_row | input | RW (4) | Current character row |
| cur_col | input | CW (5) | Current character column |
| char_dot | input | 1 | A character dot is being drawn |
| char_rgb | input | 3 | Colour of the current character dot |
| w_en | input | NWIN (3) | Per-window enable |
| wr_lo | input | NWIN*RW | Window start rows, window i at [i*RW +: RW] |
| wr_hi | input | NWIN*RW | Window end rows |
| wc_lo | input | NWIN*CW | Window start columns, window i at [i*CW +: CW] |
| wc_hi | input | NWIN*CW | Window end columns |
| w_rgb | input | NWIN*3 | Window colours, window i at [i*3 +: 3] |
| rgb_out | output | 3 | Final R, G, B |
| htone | output | 1 | Half-tone |
| fblank | output | 1 | Fast blank |
| out_en | output | 1 | Outputs-active flag |

## Verification
Every result lags its inputs by exactly one rising edge, because there is a single register stage between inputs and outputs. The bench changes inputs on the falling edge, waits for the next rising edge, and samples shortly after it, so each check sees the response to exactly one input set. The assertions compare outputs against `$past` of the inputs one cycle back, which encodes the same one-cycle delay.

// File: rtl/osd_window_mixer.sv
module osd_window_mixer #(
  parameter int NWIN = 3,
  parameter int RW   = 4,
  parameter int CW   = 5,
  parameter int ROWS = 10,
  parameter int COLS = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               disp_en,
  input  logic               fb_char_only,
  input  logic [RW-1:0]      cur_row,
  input  logic [CW-1:0]      cur_col,
  input  logic               char_dot,
  input  logic [2:0]         char_rgb,
  input  logic [NWIN-1:0]    w_en,
  input  logic [NWIN*RW-1:0] wr_lo,
  input  logic [NWIN*RW-1:0] wr_hi,
  input  logic [NWIN*CW-1:0] wc_lo,
  input  logic [NWIN*CW-1:0] wc_hi,
  input  logic [NWIN*3-1:0]  w_rgb,
  output logic [2:0]         rgb_out,
  output logic               htone,
  output logic               fblank,
  output logic               out_en
);
  localparam logic [RW-1:0] ROW_LIM = RW'(ROWS);
  localparam logic [CW-1:0] COL_LIM = CW'(COLS);

  logic [NWIN-1:0] hit;
  logic [2:0]      win_col;
  logic            in_grid, in_win, tone_d;

  assign in_grid = (cur_row < ROW_LIM) && (cur_col < COL_LIM);

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic [RW-1:0] rlo, rhi;
    logic [CW-1:0] clo, chi;
    assign rlo = wr_lo[g*RW +: RW];
    assign rhi = wr_hi[g*RW +: RW];
    assign clo = wc_lo[g*CW +: CW];
    assign chi = wc_hi[g*CW +: CW];
    assign hit[g] = w_en[g] && in_grid &&
                    (cur_row >= rlo) && (cur_row <= rhi) &&
                    (cur_col >= clo) && (cur_col <= chi);
  end

  always_comb begin
    win_col = '0;
    for (int i = NWIN - 1; i >= 0; i--)
      if (hit[i]) win_col = w_rgb[i*3 +: 3];
  end

  assign in_win = |hit;
  assign tone_d = disp_en && in_win && !char_dot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_out <= '0;
      htone   <= 1'b0;
      fblank  <= 1'b0;
      out_en  <= 1'b0;
    end else begin
      rgb_out <= disp_en ? ((char_dot ? char_rgb : 3'b000) |
                            (tone_d ? win_col : 3'b000)) : 3'b000;
      htone   <= tone_d;
      fblank  <= disp_en && (char_dot || (!fb_char_only && in_win));
      out_en  <= disp_en;
    end
  end
endmodule

// File: rtl/osd_window_mixer_chk.sv
module osd_window_mixer_chk #(
  parameter int NWIN = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            disp_en,
  input logic            fb_char_only,
  input logic            char_dot,
  input logic [2:0]      char_rgb,
  input logic [NWIN-1:0] w_en,
  input logic [2:0]      rgb_out,
  input logic            htone,
  input logic            fblank,
  input logic            out_en
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    primed && !$past(disp_en) |-> (rgb_out == 3'b000) && !htone && !fblank && !out_en);

  assert_enable_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(disp_en) |-> out_en);

  assert_no_tone_on_dot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(char_dot) |-> !htone);

  assert_no_window_no_tone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    primed && ($past(w_en) == '0) |-> !htone);

  assert_char_colour_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(disp_en && char_dot) |-> ((rgb_out & $past(char_rgb)) == $past(char_rgb)));

  assert_dot_blanks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(disp_en && char_dot) |-> fblank);

  assert_char_only_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(fb_char_only && !char_dot) |-> !fblank);

  assert_tone_implies_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    primed && htone && !$past(fb_char_only) |-> fblank);
endmodule

bind osd_window_mixer osd_window_mixer_chk #(.NWIN(NWIN)) u_chk (.*);

// File: tb/osd_window_mixer_bench.sv
module osd_window_mixer_bench;
  localparam int NWIN = 3, RW = 4, CW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_en = 1'b0, fb_char_only = 1'b0, char_dot = 1'b0;
  logic [RW-1:0] cur_row = '0;
  logic [CW-1:0] cur_col = '0;
  logic [2:0] char_rgb = '0;
  logic [NWIN-1:0] w_en = '0;
  logic [3:0] rlo [NWIN], rhi [NWIN];
  logic [4:0] clo [NWIN], chi [NWIN];
  logic [2:0] wcol [NWIN];
  logic [NWIN*RW-1:0] wr_lo, wr_hi;
  logic [NWIN*CW-1:0] wc_lo, wc_hi;
  logic [NWIN*3-1:0] w_rgb;
  logic [2:0] rgb_out;
  logic htone, fblank, out_en;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  always_comb
    for (int i = 0; i < NWIN; i++) begin
      wr_lo[i*RW +: RW] = rlo[i];
      wr_hi[i*RW +: RW] = rhi[i];
      wc_lo[i*CW +: CW] = clo[i];
      wc_hi[i*CW +: CW] = chi[i];
      w_rgb[i*3 +: 3]   = wcol[i];
    end

  osd_window_mixer u_osd_window_mixer (
    .clk, .rst_n, .disp_en, .fb_char_only, .cur_row, .cur_col, .char_dot,
    .char_rgb, .w_en, .wr_lo, .wr_hi, .wc_lo, .wc_hi, .w_rgb,
    .rgb_out, .htone, .fblank, .out_en);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (row %0d col %0d)", tag, act, exp, cur_row, cur_col);
    end
  endtask

  task automatic set_win(input int i, input int en, input int r0, input int r1,
                         input int c0, input int c1, input int col);
    w_en[i] = en[0]; rlo[i] = 4'(r0); rhi[i] = 4'(r1);
    clo[i] = 5'(c0); chi[i] = 5'(c1); wcol[i] = 3'(col);
  endtask

  task automatic sweep(input string tag);
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 32; c++) begin
        int sel, ew, tone, ergb, efb;
        @(negedge clk);
        cur_row = 4'(r); cur_col = 5'(c);
        char_dot = ((r + c) % 3) == 0;
        char_rgb = 3'((r * 3 + c) % 8);
        fb_char_only = r[0];
        sel = -1;
        for (int i = NWIN - 1; i >= 0; i--)
          if (w_en[i] && r < 10 && c < 24 && r >= rlo[i] && r <= rhi[i] &&
              c >= clo[i] && c <= chi[i]) sel = i;
        ew = (sel >= 0) ? wcol[sel] : 0;
        tone = (disp_en && sel >= 0 && !char_dot) ? 1 : 0;
        ergb = disp_en ? ((char_dot ? int'(char_rgb) : 0) | (tone ? ew : 0)) : 0;
        efb = (disp_en && (char_dot || (!fb_char_only && sel >= 0))) ? 1 : 0;
        @(posedge clk); #2;
        chk({tag, " R6 R10 htone"}, htone, tone);
        chk({tag, " R7 R10 rgb"}, rgb_out, ergb);
        chk({tag, " R8 fblank"}, fblank, efb);
        chk({tag, " R9 out_en"}, out_en, disp_en);
      end
  endtask

  initial begin
    for (int i = 0; i < NWIN; i++) set_win(i, 0, 0, 0, 0, 0, 0);
    #20;
    chk("R10 reset rgb", rgb_out, 0);
    chk("R10 reset htone", htone, 0);
    chk("R10 reset fblank", fblank, 0);
    chk("R10 reset out_en", out_en, 0);
    @(negedge clk); rst_n = 1'b1;
    disp_en = 1'b1;
    set_win(0, 1, 1, 3, 2, 10, 1);
    set_win(1, 1, 2, 6, 5, 15, 2);
    set_win(2, 1, 0, 9, 0, 23, 4);
    sweep("R1 R4 R5 overlap");
    set_win(0, 1, 4, 2, 1, 8, 3);
    set_win(1, 1, 3, 7, 12, 6, 5);
    set_win(2, 0, 0, 9, 0, 23, 6);
    sweep("R2 R3 inverted/disabled");
    set_win(0, 1, 9, 9, 23, 23, 7);
    set_win(1, 1, 5, 5, 0, 23, 2);
    set_win(2, 1, 0, 15, 20, 31, 1);
    sweep("R4 R5 edge");
    disp_en = 1'b0;
    sweep("R9 disabled");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule